// File: doc/BRIEF.md
# Serial Byte Receiver with Two-Step Full-Flag Release

This block receives asynchronous serial bytes on a single input line and presents each completed byte in a receive data register. A free-running divider makes a sampling tick at sixteen times the bit rate. The receiver detects a falling edge and confirms it halfway through the start bit. It then takes each of the eight data bits at the centre of its bit time, least significant bit first, and checks the stop bit. Each completed byte is loaded into the data register. The load raises a one-cycle interrupt request and sets a buffer-full status flag.

A host reads the block through two one-cycle read strobes, one for the status word and one for the data register. The full flag is not released by reading the data alone. The host must first read status while the flag is set, and then read the data. If a byte lands between those two reads, the pending release is cancelled. The host must then repeat the pair. The status word also reports an overrun, when a byte overwrites one that was never released, and a framing error, when the stop bit is sampled low.

Top module: `rx_serial_port`

## Requirements
- R1: A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit, each lasting OVERSAMPLE*TICK_DIV clocks. Each data bit is sampled near its centre, and the completed byte appears on `rxData`.
- R2: Loading a byte sets the full flag, which is status bit 0, and updates `rxData`.
- R3: `rxIrq` is high for exactly one clock per loaded byte, in the same cycle that the full flag first reads 1 after the load.
- R4: The full flag clears when a status read that returns bit 0 = 1 is followed by a data read.
- R5: A data read that has no qualifying status read before it returns the byte and leaves the full flag at 1.
- R6: If a byte loads after the status read, that read gives no release. This holds whether the read saw the flag at 0 or at 1. A following data read leaves the flag at 1. A new status read followed by a data read then clears it.
- R7: A stop bit sampled low sets the framing-error bit, which is status bit 2, and the byte is still loaded. The bit always reflects the most recently loaded byte.
- R8: A byte that loads while the full flag is 1 overwrites `rxData` and sets the overrun bit, which is status bit 1. The overrun bit clears together with the full flag in the two-step release.
- R9: A low pulse on `rxIn` that is high again at the middle of the start bit loads nothing and raises no interrupt.
- R10: After reset, `status` reads 0, `rxData` reads 0 and `rxIrq` is low. Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial line; idles high |
| statusRd | input | 1 | One-cycle status read strobe |
| dataRd | input | 1 | One-cycle data read strobe |
| rxData | output | 8 | Receive data register |
| status | output | 8 | {5'b0, framing error, overrun, full} |
| rxIrq | output | 1 | One-cycle receive interrupt request |

## Verification
A release token that stays set when it should not would let a lone data read clear the full flag. That shows on status bit 0 in the cycle after the read. A token that is never set would leave the flag stuck at 1 after a correct read pair. A sampling phase that is off by a few ticks would shift bits between neighbours, and `rxData` would show the error as soon as the interrupt fires. The hardest case places a byte load between the two reads, which is exactly where a cancelled token and a live one differ.

// File: rtl/rx_serial_pkg.sv
package rx_serial_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic load;
    logic stopBad;
  } rxStrobe_t;
endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_serial_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 4,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxS,
  output rxStrobe_t strb
);
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PH_W    = $clog2(OVERSAMPLE);
  localparam int BIT_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF    = OVERSAMPLE / 2;

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitIdx;
  rxState_t         st;
  logic             phaseEnd;

  assign tick     = (divCnt == DIV_W'(TICK_DIV - 1));
  assign phaseEnd = (phase == PH_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strb.shiftEn = (st == RX_DATA) && tick && phaseEnd;
    strb.load    = (st == RX_STOP) && tick && phaseEnd;
    strb.stopBad = strb.load && !rxS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      unique case (st)
        RX_IDLE: begin
          phase <= '0;
          if (!rxS) st <= RX_START;
        end
        RX_START: begin
          if (phase == PH_W'(HALF - 1)) begin
            phase  <= '0;
            bitIdx <= '0;
            st     <= rxS ? RX_IDLE : RX_DATA;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RX_DATA: begin
          if (phaseEnd) begin
            phase <= '0;
            if (bitIdx == BIT_W'(DATA_BITS - 1)) st <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RX_STOP: begin
          if (phaseEnd) begin
            phase <= '0;
            st    <= RX_IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_serial_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  rxStrobe_t            strb,
  output logic                 rxS,
  output logic [DATA_BITS-1:0] rxData
);
  logic [SYNC_LEN-1:0]  syncQ;
  logic [DATA_BITS-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_LEN-2:0], rxIn};
  end
  assign rxS = syncQ[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxData <= '0;
    end else begin
      if (strb.shiftEn) shiftQ <= {rxS, shiftQ[DATA_BITS-1:1]};
      if (strb.load) rxData <= shiftQ;
    end
  end
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic stopBad,
  input  logic statusRd,
  input  logic dataRd,
  output logic full,
  output logic overrun,
  output logic frameErr,
  output logic armed,
  output logic irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full     <= 1'b0;
      overrun  <= 1'b0;
      frameErr <= 1'b0;
      armed    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= load;
      if (load) begin
        full     <= 1'b1;
        overrun  <= overrun | full;
        frameErr <= stopBad;
        armed    <= 1'b0;
      end else if (dataRd && armed) begin
        full    <= 1'b0;
        overrun <= 1'b0;
        armed   <= 1'b0;
      end else if (statusRd) begin
        armed <= full;
      end
    end
  end
endmodule

// File: rtl/rx_serial_port.sv
module rx_serial_port
  import rx_serial_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 4,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 statusRd,
  input  logic                 dataRd,
  output logic [DATA_BITS-1:0] rxData,
  output logic [7:0]           status,
  output logic                 rxIrq
);
  rxStrobe_t strb;
  logic      rxS;
  logic      full, overrun, frameErr, flagArmed;

  rx_frame_ctrl #(
    .OVERSAMPLE(OVERSAMPLE), .TICK_DIV(TICK_DIV), .DATA_BITS(DATA_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxS(rxS), .strb(strb)
  );

  rx_datapath #(.DATA_BITS(DATA_BITS), .SYNC_LEN(2)) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb),
    .rxS(rxS), .rxData(rxData)
  );

  rx_status_flags u_flags (
    .clk(clk), .rstN(rstN), .load(strb.load), .stopBad(strb.stopBad),
    .statusRd(statusRd), .dataRd(dataRd), .full(full), .overrun(overrun),
    .frameErr(frameErr), .armed(flagArmed), .irq(rxIrq)
  );

  assign status = {5'b0, frameErr, overrun, full};
endmodule

// File: rtl/rx_serial_port_chk.sv
module rx_serial_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       loadStb,
  input logic       dataRd,
  input logic       armed,
  input logic [7:0] status,
  input logic       rxIrq
);
  a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> status[0]);
  a_r3_irq_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (status[0] && $past(loadStb)));
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  a_r5_clear_needs_token: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> $past(dataRd && armed));
  a_r6_load_drops_token: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !armed);
  a_r8_overrun_on_full: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && status[0]) |=> (status[1] && status[0]));
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    status[7:3] == 5'b0);
endmodule

bind rx_serial_port rx_serial_port_chk u_chk (
  .clk(clk), .rstN(rstN), .loadStb(strb.load), .dataRd(dataRd),
  .armed(flagArmed), .status(status), .rxIrq(rxIrq)
);

// File: tb/sim_rx_serial_port.sv
module sim_rx_serial_port;
  localparam int BIT_CLKS = 16 * 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       statusRd = 1'b0;
  logic       dataRd = 1'b0;
  logic [7:0] rxData, status;
  logic       rxIrq;

  int checks = 0;
  int fails = 0;
  int irqCount = 0;
  int irqBad = 0;
  logic irqPrev = 1'b0;
  logic [7:0] rdVal;

  always #10 clk = ~clk;

  rx_serial_port u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .statusRd(statusRd),
    .dataRd(dataRd), .rxData(rxData), .status(status), .rxIrq(rxIrq)
  );

  always @(negedge clk) begin
    if (rxIrq) begin
      irqCount++;
      if (!status[0] || irqPrev) irqBad++;
    end
    irqPrev <= rxIrq;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit goodStop);
    @(negedge clk) rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxIn = goodStop;
    repeat (goodStop ? BIT_CLKS : 40) @(negedge clk);
    rxIn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] v);
    @(negedge clk) statusRd = 1'b1; v = status;
    @(negedge clk) statusRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic readData(output logic [7:0] v);
    @(negedge clk) dataRd = 1'b1; v = rxData;
    @(negedge clk) dataRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic releasePair();
    logic [7:0] v;
    readStatus(v);
    readData(v);
  endtask

  task automatic testReset();
    check(status == 8'h00, "R10 status after reset", status, 0);
    check(rxData == 8'h00, "R10 data after reset", rxData, 0);
    check(rxIrq == 1'b0, "R10 irq after reset", rxIrq, 0);
  endtask

  task automatic testBasic();
    int c0 = irqCount;
    sendByte(8'hA5, 1'b1);
    check(rxData == 8'hA5, "R1 byte A5", rxData, 8'hA5);
    check(status == 8'h01, "R2 full after load", status, 1);
    check(irqCount == c0 + 1, "R3 one irq per byte", irqCount - c0, 1);
    readStatus(rdVal);
    check(rdVal == 8'h01, "R4 status read sees full", rdVal, 1);
    readData(rdVal);
    check(rdVal == 8'hA5, "R4 data read value", rdVal, 8'hA5);
    check(status == 8'h00, "R4 pair clears full", status, 0);
    sendByte(8'h3C, 1'b1);
    check(rxData == 8'h3C, "R1 byte 3C", rxData, 8'h3C);
    releasePair();
  endtask

  task automatic testLoneData();
    sendByte(8'h96, 1'b1);
    readData(rdVal);
    check(rdVal == 8'h96, "R5 lone read returns data", rdVal, 8'h96);
    check(status[0] == 1'b1, "R5 lone read keeps full", status[0], 1);
    readData(rdVal);
    check(status[0] == 1'b1, "R5 second lone read keeps full", status[0], 1);
    releasePair();
    check(status == 8'h00, "R4 pair after lone reads", status, 0);
  endtask

  task automatic testLateSet();
    readStatus(rdVal);
    check(rdVal == 8'h00, "R6 status read while empty", rdVal, 0);
    sendByte(8'h5A, 1'b1);
    readData(rdVal);
    check(status[0] == 1'b1, "R6 early status read gives no clear", status[0], 1);
    releasePair();
    check(status == 8'h00, "R6 second pair clears", status, 0);
    sendByte(8'h55, 1'b1);
    readStatus(rdVal);
    sendByte(8'h66, 1'b1);
    readData(rdVal);
    check(rdVal == 8'h66, "R8 overwrite data", rdVal, 8'h66);
    check(status == 8'h03, "R6 token lost to new load", status, 3);
    releasePair();
    check(status == 8'h00, "R6 fresh pair clears", status, 0);
  endtask

  task automatic testFraming();
    int c0 = irqCount;
    sendByte(8'h81, 1'b0);
    check(rxData == 8'h81, "R7 byte loaded despite bad stop", rxData, 8'h81);
    check(status == 8'h05, "R7 framing error bit", status, 5);
    check(irqCount == c0 + 1, "R9 no spurious frame after low stop", irqCount - c0, 1);
    releasePair();
    sendByte(8'h42, 1'b1);
    check(status == 8'h01, "R7 framing bit follows latest byte", status, 1);
    releasePair();
  endtask

  task automatic testOverrun();
    sendByte(8'h11, 1'b1);
    check(status == 8'h01, "R8 no overrun on first", status, 1);
    sendByte(8'h22, 1'b1);
    check(rxData == 8'h22, "R8 buffer overwritten", rxData, 8'h22);
    check(status == 8'h03, "R8 overrun set", status, 3);
    releasePair();
    check(status == 8'h00, "R8 overrun cleared by pair", status, 0);
  endtask

  task automatic testFalseStart();
    int c0 = irqCount;
    @(negedge clk) rxIn = 1'b0;
    repeat (16) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check(irqCount == c0, "R9 no irq on glitch", irqCount - c0, 0);
    check(status == 8'h00, "R9 no load on glitch", status, 0);
    sendByte(8'hC3, 1'b1);
    check(rxData == 8'hC3, "R9 receiver recovers", rxData, 8'hC3);
    releasePair();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testBasic();
    testLoneData();
    testLateSet();
    testFraming();
    testOverrun();
    testFalseStart();
    check(irqBad == 0, "R3 irq single cycle with full", irqBad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule